// File: doc/BRIEF.md
# Lazy wide adder/subtracter for Montgomery-domain field operations

This block performs the additions and subtractions that sit between Montgomery multiplications in prime-field elliptic curve arithmetic. It never reduces its result modulo the field prime. An addition returns the plain integer sum. A subtraction returns the difference plus a fixed offset equal to four times the multiplier's working modulus M̃. With these rules every result stays inside (0, 8·M̃). A following Montgomery multiplication whose constant R exceeds 64·M̃ accepts any value in that range as an input, so no reduction is needed here.

Both operands are as wide as the multiplier's parallel data bus. The block does not build one full-width carry chain. It first folds the three terms of a subtraction, A, the inverted B and 4·M̃, into a sum word and a carry word with a single carry-save layer. It then resolves that pair through a narrow carry-propagate adder, one chunk per cycle, starting at the least significant chunk. A one-cycle `done` pulse marks a valid result. A diagnostic flag reports a result that is not below 8·M̃.

Top module: `lazy_addsub`

## Requirements
- R1: While `rst_n` is low, and after it rises, `result` is zero and `busy`, `done` and `oor` are low. This also holds when reset interrupts an operation in progress.
- R2: With `sub`=0 at the accepted start, the final `result` equals (A + B) mod 2^W.
- R3: With `sub`=1 at the accepted start, the final `result` equals (A − B + `off4m`) mod 2^W.
- R4: A start is accepted when `start` is high and `busy` is low at a rising edge. `busy` is then high for exactly NCH = ceil(W/CW) cycles. `done` is high for exactly one cycle, the cycle that begins with the NCH-th rising edge after the accepting edge. `done` and `busy` are never high together.
- R5: A `start` that is high while `busy` is high is ignored. The running operation completes with its own result and no second `done` follows.
- R6: Carries and borrows propagate across every chunk boundary of width CW, for example 2^54−1 + 1 = 2^54, and 0 − 1 + `off4m` = `off4m` − 1.
- R7: `oor` is high only while `done` is high. It is high exactly when `result` ≥ 2·`off4m` (that is, ≥ 8·M̃), using the `off4m` captured at start.
- R8: While `busy` is low, `result` holds its value from one cycle to the next.
- R9: `a`, `b`, `sub` and `off4m` are sampled only at the accepting edge. Changing them while `busy` is high does not alter the result.
- R10: For operands A, B < 4·M̃ with the sum or difference inside the range, the result is congruent to A ± B modulo M̃ and lies strictly between 0 and 8·M̃.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an operation; accepted only while idle |
| sub | input | 1 | 0 selects A + B, 1 selects A − B + 4·M̃ |
| a | input | W | Operand A |
| b | input | W | Operand B |
| off4m | input | W | Stored constant 4·M̃ |
| result | output | W | Result, valid while `done` is high and held while idle |
| busy | output | 1 | Chunked addition in progress |
| done | output | 1 | One-cycle pulse: result valid |
| oor | output | 1 | Result not below 8·M̃; only meaningful with `done` |

## Verification
Several properties are checked on every cycle. `done` lasts a single cycle and arrives after exactly NCH busy cycles. An accepted start always raises `busy`. The result cannot move while the block is idle. The range flag can only appear together with `done`. The values themselves can only be shown by the bench's scenarios. These cover carry ripple through every chunk boundary, borrow through the offset, congruence modulo M̃, the exact 8·M̃ edge of the range flag, ignored starts, operands changed while busy, and reset in the middle of an operation.

// File: rtl/lazy_addsub.sv
module lazy_addsub #(
  parameter int W  = 256,
  parameter int CW = 54
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] off4m,
  output logic [W-1:0] result,
  output logic         busy,
  output logic         done,
  output logic         oor
);
  localparam int NCH = (W + CW - 1) / CW;
  localparam int PW  = NCH * CW;
  localparam int IW  = $clog2(NCH + 1);

  logic [PW-1:0] s_q, c_q, r_q;
  logic [W-1:0]  lim_q;
  logic [IW-1:0] idx_q;
  logic          cy_q;

  wire           take = start && !busy;
  wire [W-1:0]   bx   = sub ? ~b : b;
  wire [W-1:0]   mx   = sub ? off4m : '0;
  wire [W-1:0]   cs_s = a ^ bx ^ mx;
  wire [W-1:0]   maj  = (a & bx) | (a & mx) | (bx & mx);
  wire [W-1:0]   cs_c = {maj[W-2:0], 1'b0};
  wire [CW:0]    csum = {1'b0, s_q[CW-1:0]} + {1'b0, c_q[CW-1:0]} + {{CW{1'b0}}, cy_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q   <= '0;
      c_q   <= '0;
      r_q   <= '0;
      lim_q <= '0;
      idx_q <= '0;
      cy_q  <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take) begin
        s_q   <= PW'(cs_s);
        c_q   <= PW'(cs_c);
        cy_q  <= sub;
        lim_q <= off4m;
        idx_q <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        s_q   <= s_q >> CW;
        c_q   <= c_q >> CW;
        r_q   <= {csum[CW-1:0], r_q[PW-1:CW]};
        cy_q  <= csum[CW];
        idx_q <= idx_q + 1'b1;
        if (idx_q == IW'(NCH - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign result = r_q[W-1:0];
  assign oor    = done && ({1'b0, result} >= {lim_q, 1'b0});
endmodule

// File: rtl/lazy_addsub_chk.sv
module lazy_addsub_chk #(
  parameter int W  = 256,
  parameter int CW = 54
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         oor,
  input logic [W-1:0] result
);
  localparam int NCH = (W + CW - 1) / CW;
  localparam int KW  = $clog2(NCH + 2);

  logic [KW-1:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else        busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
  AST_ACCEPT:     assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R4
  AST_LATENCY:    assert property (@(posedge clk) disable iff (!rst_n) done |-> (busy_cnt == KW'(NCH))); // R4
  AST_EXCLUSIVE:  assert property (@(posedge clk) disable iff (!rst_n) !(done && busy)); // R4
  AST_IDLE_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !busy |=> $stable(result)); // R8
  AST_OOR_DONE:   assert property (@(posedge clk) disable iff (!rst_n) oor |-> done); // R7
endmodule

bind lazy_addsub lazy_addsub_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .oor(oor), .result(result)
);

// File: tb/lazy_addsub_bench.sv
`timescale 1ns/1ps
module lazy_addsub_bench;
  localparam int W   = 256;
  localparam int CW  = 54;
  localparam int NCH = (W + CW - 1) / CW;
  localparam logic [W-1:0] MT = (256'd1 << 250) - 256'd189;
  localparam logic [W-1:0] M4 = MT << 2;
  localparam int NV = 10;
  localparam logic         VS [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [W-1:0] VA [NV] = '{256'd1, (MT << 1) - 1, M4 + 3, (256'd1 << 54) - 1, (256'd1 << 216) - 1,
                                        256'd5, (MT << 1) - 1, (MT << 1) - 1, 256'd0, MT + 17};
  localparam logic [W-1:0] VB [NV] = '{256'd1, (MT << 1) - 1, (MT << 1) + 7, 256'd1, 256'd1,
                                        256'd7, M4 - 1, 256'd1, 256'd1, (MT << 1) + 9};

  logic clk = 0, rst_n = 0, start = 0, sub = 0;
  logic [W-1:0] a = '0, b = '0, off4m = M4;
  logic [W-1:0] result;
  logic busy, done, oor;
  int total = 0, bad = 0;
  int lat;

  always #2.5 clk = ~clk;

  lazy_addsub #(.W(W), .CW(CW)) u_lazy_addsub (
    .clk(clk), .rst_n(rst_n), .start(start), .sub(sub), .a(a), .b(b),
    .off4m(off4m), .result(result), .busy(busy), .done(done), .oor(oor)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic s, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    sub = s; a = x; b = y; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic logic [W-1:0] expect_val(input logic s, input logic [W-1:0] x, input logic [W-1:0] y);
    return s ? (x - y + M4) : (x + y);
  endfunction

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(result == '0 && !busy && !done && !oor, "R1 in reset", result, '0);
    rst_n = 1;
    @(negedge clk);
    chk(result == '0 && !busy && !done, "R1 after reset", result, '0);

    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] e;
      logic [W+1:0] lhs, rhs;
      e = expect_val(VS[i], VA[i], VB[i]);
      issue(VS[i], VA[i], VB[i]);
      chk(busy, "R4 busy after start", {255'd0, busy}, 256'd1);
      wait_done(lat);
      chk(lat == NCH, "R4 latency", W'(lat), W'(NCH));
      chk(result == e, VS[i] ? "R3 sub value" : "R2 add value", result, e);
      chk(oor == 1'b0, "R7 in range", {255'd0, oor}, '0);
      lhs = (W+2)'(result) % (W+2)'(MT);
      rhs = VS[i] ? (((W+2)'(VA[i]) % MT) + MT - ((W+2)'(VB[i]) % MT)) % MT
                  : (((W+2)'(VA[i]) % MT) + ((W+2)'(VB[i]) % MT)) % MT;
      chk(lhs == rhs && result != '0 && result < (MT << 3), "R10 congruence and bound", lhs[W-1:0], rhs[W-1:0]);
      @(negedge clk);
      chk(!done, "R4 single pulse", {255'd0, done}, '0);
    end

    // R6: carries through every chunk boundary
    issue(1'b0, (256'd1 << 216) - 1, 256'd1);
    wait_done(lat);
    chk(result == (256'd1 << 216), "R6 add ripple", result, 256'd1 << 216);
    issue(1'b1, 256'd0, 256'd1);
    wait_done(lat);
    chk(result == M4 - 1, "R6 borrow ripple", result, M4 - 1);

    // R7: exactly 8*M flags, one below does not
    issue(1'b0, M4, M4);
    wait_done(lat);
    chk(oor == 1'b1 && result == (MT << 3), "R7 at bound", result, MT << 3);
    @(negedge clk);
    chk(oor == 1'b0, "R7 only with done", {255'd0, oor}, '0);
    issue(1'b0, M4, M4 - 1);
    wait_done(lat);
    chk(oor == 1'b0, "R7 below bound", {255'd0, oor}, '0);

    // R8: result held while idle
    repeat (4) @(negedge clk);
    chk(result == (MT << 3) - 1, "R8 hold", result, (MT << 3) - 1);

    // R5: start while busy ignored
    issue(1'b0, 256'd100, 256'd23);
    start = 1; a = 256'd7; b = 256'd7;
    @(negedge clk);
    start = 0;
    wait_done(lat);
    chk(result == 256'd123, "R5 ignored start", result, 256'd123);
    repeat (NCH + 2) begin
      @(negedge clk);
      chk(!done && !busy, "R5 no second op", {254'd0, done, busy}, '0);
    end

    // R9: inputs changed while busy
    issue(1'b1, 256'd50, 256'd8);
    a = 256'd999; b = 256'd1; sub = 0; off4m = '0;
    wait_done(lat);
    chk(result == M4 + 42, "R9 sampled at start", result, M4 + 42);
    off4m = M4;

    // R1: reset mid-operation
    issue(1'b0, 256'd3, 256'd4);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(result == '0 && !busy && !done, "R1 mid-op reset", result, '0);
    rst_n = 1;
    repeat (NCH + 2) @(negedge clk);
    chk(result == '0 && !done, "R1 stays idle", result, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule